// File: doc/BRIEF.md
# Alternating L1-to-L2 Miss Arbiter

This block is the path from a core's two first-level miss tables to its private second-level cache. It owns one miss table for instruction fetches and one for loads and stores. New misses arrive on an allocation stream for each side. Each entry waits out the first-level detect latency. Then it probes the second-level tags over a lookup port. The hit or miss answer comes back on `lkp_hit` in the same cycle. Both sides may probe in the same cycle. They are served one after the other, and the side served first swaps on every clock.

A probe that hits gives the entry a completion time 18 cycles later. The entry is then offered on that side's completion stream. A probe that misses copies the entry into a shared second-level miss queue, with a due time 18 cycles later. Once that time is reached, the queue head is offered to the next level down. The entry stays in its table until a fill marks it complete.

An entry that has probed successfully never probes again. If the miss queue has no room, the probe is refused and the entry keeps its state. All streams use valid/ready. A transfer happens on a clock edge where both are high. While valid is high and ready is low, the offer is held. A held offer is only replaced by a lower slot that becomes eligible on the same side. An internal cycle counter starts at 1 after reset, and every time in this brief is measured on it.

Top module: `l2_miss_arbiter`

## Requirements
- R1: After reset, both tables and the miss queue are empty. `alloc_ready` is 2'b11. `lkp_valid`, `cpl_valid` and `mb_valid` are 0, and all counters read 0.
- R2: An entry accepted on side s in cycle n first raises `lkp_valid[s]` in cycle n+L1_LAT (default 2), not before.
- R3: Each side presents at most one probe per cycle: the lowest-numbered slot that is due. Once a probe is taken, the entry never probes again.
- R4: In the first cycle after reset the instruction side (index 0) is served first, and the order swaps every cycle. When the miss queue has room for one entry only, the first-served miss takes it.
- R5: A probe that hits in cycle p raises that side's `cpl_valid` in cycle p+L2_LAT (default 18), not before.
- R6: A probe that misses in cycle p enters the miss queue. It is offered on `mb_valid` from cycle p+L2_LAT, in the order it was queued. It carries `mb_src` (0 instruction, 1 data), its table slot, its address and its store flag.
- R7: A miss that finds the queue full is refused. The entry stays due and keeps probing each cycle until it is accepted.
- R8: `lkp_store[0]` is 0 whatever `alloc_store[0]` was. `lkp_store[1]` equals the store flag given at allocation.
- R9: A fill (`fill_valid`, `fill_src`, `fill_slot`) on an entry that missed raises `cpl_valid` in the next cycle. A fill on a free or still-pending slot is ignored.
- R10: A completion is held until `cpl_ready` is seen. The lowest-numbered completed slot is offered first, and the slot is freed on the handshake.
- R11: `acc_cnt[s]` counts accepted probes of side s, and `hit_cnt[s]` counts those that hit.
- R12: `alloc_ready[s]` is 0 while all SRC_DEPTH slots of side s are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 2 | New miss offered, per side (0 instruction, 1 data) |
| alloc_ready | output | 2 | Free slot available, per side |
| alloc_addr | input | 2 x AW | Miss address, per side |
| alloc_store | input | 2 | Store flag, per side |
| lkp_valid | output | 2 | Probe to second-level tags, per side |
| lkp_addr | output | 2 x AW | Probe address |
| lkp_store | output | 2 | Probe is a store access |
| lkp_hit | input | 2 | Same-cycle tag answer, per side |
| mb_valid | output | 1 | Miss-queue head is due |
| mb_ready | input | 1 | Lower level takes the head |
| mb_src | output | 1 | Side of head entry |
| mb_slot | output | SW | Table slot of head entry |
| mb_addr | output | AW | Address of head entry |
| mb_store | output | 1 | Store flag of head entry |
| fill_valid | input | 1 | Data for a queued miss has returned |
| fill_src | input | 1 | Side of filled entry |
| fill_slot | input | SW | Slot of filled entry |
| cpl_valid | output | 2 | Completed entry offered, per side |
| cpl_ready | input | 2 | Completion accepted, per side |
| cpl_slot | output | 2 x SW | Slot being completed |
| acc_cnt | output | 2 x CNT_W | Accepted probes, per side |
| hit_cnt | output | 2 x CNT_W | Hits, per side |

## Verification
The assertions assume three things about the inputs:
- `lkp_hit` answers within the same cycle whenever `lkp_valid` is high.
- A fill names only an entry whose miss was queued.
- No entry's lifetime spans a wrap of the CW-bit cycle counter.

The stimulus keeps within these limits. Hit answers are driven before the edge that takes the probe. Fills go only to slots whose misses were popped, apart from one deliberately ignored fill on a free slot. Each run lasts a few hundred cycles, far below the counter range. The miss queue is built two deep so that the single-room case can be reached.

// File: rtl/l2arb_pkg.sv
package l2arb_pkg;
  localparam int NSIDE = 2;
  localparam logic SIDE_INSTR = 1'b0;
  localparam logic SIDE_DATA  = 1'b1;
endpackage

// File: rtl/l2arb_slot_table.sv
module l2arb_slot_table #(
  parameter int DEPTH   = 4,
  parameter int SW      = 2,
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int L1_LAT  = 2,
  parameter int L2_LAT  = 18,
  parameter bit IS_DATA = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [AW-1:0] alloc_addr,
  input  logic          alloc_store,
  output logic          pick_valid,
  output logic [SW-1:0] pick_slot,
  output logic [AW-1:0] pick_addr,
  output logic          pick_store,
  input  logic          take,
  input  logic          take_hit,
  input  logic          fill_valid,
  input  logic [SW-1:0] fill_slot,
  output logic          cpl_valid,
  input  logic          cpl_ready,
  output logic [SW-1:0] cpl_slot
);
  logic [DEPTH-1:0] used;
  logic [DEPTH-1:0] store_q;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [CW-1:0]    det_q  [DEPTH];
  logic [CW-1:0]    done_q [DEPTH];

  logic [SW-1:0] free_slot;
  logic          alloc_fire, cpl_fire, fill_ok, store_in;

  assign store_in = IS_DATA ? alloc_store : 1'b0;

  always_comb begin
    alloc_ready = 1'b0;
    free_slot   = '0;
    pick_valid  = 1'b0;
    pick_slot   = '0;
    cpl_valid   = 1'b0;
    cpl_slot    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!used[i]) begin
        alloc_ready = 1'b1;
        free_slot   = SW'(i);
      end
      if (used[i] && det_q[i] != '0 && det_q[i] <= now) begin
        pick_valid = 1'b1;
        pick_slot  = SW'(i);
      end
      if (used[i] && det_q[i] == '0 && done_q[i] != '0 && done_q[i] <= now) begin
        cpl_valid = 1'b1;
        cpl_slot  = SW'(i);
      end
    end
  end

  assign pick_addr  = addr_q[pick_slot];
  assign pick_store = store_q[pick_slot];
  assign alloc_fire = alloc_valid & alloc_ready;
  assign cpl_fire   = cpl_valid & cpl_ready;
  assign fill_ok    = fill_valid & used[fill_slot] & (det_q[fill_slot] == '0)
                      & (done_q[fill_slot] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used    <= '0;
      store_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        det_q[i]  <= '0;
        done_q[i] <= '0;
      end
    end else begin
      if (alloc_fire) begin
        used[free_slot]    <= 1'b1;
        addr_q[free_slot]  <= alloc_addr;
        store_q[free_slot] <= store_in;
        det_q[free_slot]   <= now + CW'(L1_LAT);
        done_q[free_slot]  <= '0;
      end
      if (take) begin
        det_q[pick_slot] <= '0;
        if (take_hit) done_q[pick_slot] <= now + CW'(L2_LAT);
      end
      if (fill_ok) done_q[fill_slot] <= now;
      if (cpl_fire) begin
        used[cpl_slot]   <= 1'b0;
        done_q[cpl_slot] <= '0;
      end
    end
  end

  // R3: a slot whose probe was taken is not presented again next cycle
  assert_sent_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !(pick_valid && pick_slot == $past(pick_slot)));

  // R10: an unaccepted completion stays offered
  assert_cpl_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> cpl_valid);

  // R12: an accepted allocation occupies a slot that was free
  assert_alloc_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> used[$past(free_slot)]);
endmodule

// File: rtl/l2arb_miss_queue.sv
module l2arb_miss_queue #(
  parameter int DEPTH = 4,
  parameter int SW    = 2,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int RW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] now,
  input  logic          push0,
  input  logic          p0_src,
  input  logic [SW-1:0] p0_slot,
  input  logic [AW-1:0] p0_addr,
  input  logic          p0_store,
  input  logic [CW-1:0] p0_due,
  input  logic          push1,
  input  logic          p1_src,
  input  logic [SW-1:0] p1_slot,
  input  logic [AW-1:0] p1_addr,
  input  logic          p1_store,
  input  logic [CW-1:0] p1_due,
  output logic [RW-1:0] room,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_src,
  output logic [SW-1:0] out_slot,
  output logic [AW-1:0] out_addr,
  output logic          out_store
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          m_src   [DEPTH];
  logic [SW-1:0] m_slot  [DEPTH];
  logic [AW-1:0] m_addr  [DEPTH];
  logic          m_store [DEPTH];
  logic [CW-1:0] m_due   [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr2;
  logic [RW-1:0] count;
  logic          pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign room      = RW'(DEPTH) - count;
  assign out_valid = (count != '0) && (m_due[rd_q] <= now);
  assign out_src   = m_src[rd_q];
  assign out_slot  = m_slot[rd_q];
  assign out_addr  = m_addr[rd_q];
  assign out_store = m_store[rd_q];
  assign pop       = out_valid & out_ready;
  assign wr2       = push0 ? nxt(wr_q) : wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        m_src[i]   <= 1'b0;
        m_slot[i]  <= '0;
        m_addr[i]  <= '0;
        m_store[i] <= 1'b0;
        m_due[i]   <= '0;
      end
    end else begin
      if (push0) begin
        m_src[wr_q]   <= p0_src;
        m_slot[wr_q]  <= p0_slot;
        m_addr[wr_q]  <= p0_addr;
        m_store[wr_q] <= p0_store;
        m_due[wr_q]   <= p0_due;
      end
      if (push1) begin
        m_src[wr2]   <= p1_src;
        m_slot[wr2]  <= p1_slot;
        m_addr[wr2]  <= p1_addr;
        m_store[wr2] <= p1_store;
        m_due[wr2]   <= p1_due;
      end
      if (push1)      wr_q <= nxt(wr2);
      else if (push0) wr_q <= nxt(wr_q);
      if (pop) rd_q <= nxt(rd_q);
      count <= count + RW'(push0) + RW'(push1) - RW'(pop);
    end
  end

  // R7: pushes never exceed capacity
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= RW'(DEPTH));

  // R6: a due head stays offered until taken
  assert_head_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/l2_miss_arbiter.sv
module l2_miss_arbiter
  import l2arb_pkg::*;
#(
  parameter int SRC_DEPTH = 4,
  parameter int MB_DEPTH  = 4,
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int L1_LAT    = 2,
  parameter int L2_LAT    = 18,
  parameter int CNT_W     = 16,
  localparam int SW       = $clog2(SRC_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSIDE-1:0]           alloc_valid,
  output logic [NSIDE-1:0]           alloc_ready,
  input  logic [NSIDE-1:0][AW-1:0]   alloc_addr,
  input  logic [NSIDE-1:0]           alloc_store,
  output logic [NSIDE-1:0]           lkp_valid,
  output logic [NSIDE-1:0][AW-1:0]   lkp_addr,
  output logic [NSIDE-1:0]           lkp_store,
  input  logic [NSIDE-1:0]           lkp_hit,
  output logic                       mb_valid,
  input  logic                       mb_ready,
  output logic                       mb_src,
  output logic [SW-1:0]              mb_slot,
  output logic [AW-1:0]              mb_addr,
  output logic                       mb_store,
  input  logic                       fill_valid,
  input  logic                       fill_src,
  input  logic [SW-1:0]              fill_slot,
  output logic [NSIDE-1:0]           cpl_valid,
  input  logic [NSIDE-1:0]           cpl_ready,
  output logic [NSIDE-1:0][SW-1:0]   cpl_slot,
  output logic [NSIDE-1:0][CNT_W-1:0] acc_cnt,
  output logic [NSIDE-1:0][CNT_W-1:0] hit_cnt
);
  localparam int RW = $clog2(MB_DEPTH + 1);

  logic [CW-1:0]          now;
  logic                   turn;
  logic                   first, second;
  logic                   miss_f, miss_s, push_f, push_s;
  logic [NSIDE-1:0]       take;
  logic [NSIDE-1:0][SW-1:0] pslot;
  logic [RW-1:0]          room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now  <= CW'(1);
      turn <= SIDE_INSTR;
    end else begin
      now  <= now + CW'(1);
      turn <= ~turn;
    end
  end

  assign first  = turn;
  assign second = ~turn;

  always_comb begin
    miss_f = lkp_valid[first] & ~lkp_hit[first];
    miss_s = lkp_valid[second] & ~lkp_hit[second];
    push_f = miss_f && (room != '0);
    push_s = miss_s && (int'(room) >= (push_f ? 2 : 1));
    take         = '0;
    take[first]  = lkp_valid[first] & (lkp_hit[first] | push_f);
    take[second] = lkp_valid[second] & (lkp_hit[second] | push_s);
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    l2arb_slot_table #(
      .DEPTH(SRC_DEPTH), .SW(SW), .AW(AW), .CW(CW),
      .L1_LAT(L1_LAT), .L2_LAT(L2_LAT), .IS_DATA(s == 1)
    ) u_tab (
      .clk(clk), .rst_n(rst_n), .now(now),
      .alloc_valid(alloc_valid[s]), .alloc_ready(alloc_ready[s]),
      .alloc_addr(alloc_addr[s]), .alloc_store(alloc_store[s]),
      .pick_valid(lkp_valid[s]), .pick_slot(pslot[s]),
      .pick_addr(lkp_addr[s]), .pick_store(lkp_store[s]),
      .take(take[s]), .take_hit(lkp_hit[s]),
      .fill_valid(fill_valid && (fill_src == 1'(s))), .fill_slot(fill_slot),
      .cpl_valid(cpl_valid[s]), .cpl_ready(cpl_ready[s]), .cpl_slot(cpl_slot[s])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_cnt[s] <= '0;
        hit_cnt[s] <= '0;
      end else if (take[s]) begin
        acc_cnt[s] <= acc_cnt[s] + CNT_W'(1);
        if (lkp_hit[s]) hit_cnt[s] <= hit_cnt[s] + CNT_W'(1);
      end
    end

    // R11: hits never outnumber accepted probes
    assert_hits_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cnt[s] <= acc_cnt[s]);

    // R11: at most one accepted probe per side per cycle
    assert_acc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (acc_cnt[s] - $past(acc_cnt[s])) <= CNT_W'(1));
  end

  l2arb_miss_queue #(
    .DEPTH(MB_DEPTH), .SW(SW), .AW(AW), .CW(CW), .RW(RW)
  ) u_mq (
    .clk(clk), .rst_n(rst_n), .now(now),
    .push0(push_f), .p0_src(first), .p0_slot(pslot[first]),
    .p0_addr(lkp_addr[first]), .p0_store(lkp_store[first]),
    .p0_due(now + CW'(L2_LAT)),
    .push1(push_s), .p1_src(second), .p1_slot(pslot[second]),
    .p1_addr(lkp_addr[second]), .p1_store(lkp_store[second]),
    .p1_due(now + CW'(L2_LAT)),
    .room(room),
    .out_valid(mb_valid), .out_ready(mb_ready), .out_src(mb_src),
    .out_slot(mb_slot), .out_addr(mb_addr), .out_store(mb_store)
  );

  // R4: the second-served miss never overtakes a refused first-served miss
  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_s && miss_f && !push_f));

  // R7: a refused miss keeps probing in the next cycle
  assert_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid[first] && !take[first]) |=> lkp_valid[$past(first)]);
endmodule

// File: tb/sim_l2_miss_arbiter.sv
`timescale 1ns/1ps
module sim_l2_miss_arbiter;
  localparam int AW = 32;
  localparam int SW = 2;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]          alloc_valid, alloc_ready, alloc_store;
  logic [1:0][AW-1:0]  alloc_addr;
  logic [1:0]          lkp_valid, lkp_store, lkp_hit;
  logic [1:0][AW-1:0]  lkp_addr;
  logic                mb_valid, mb_ready, mb_src, mb_store;
  logic [SW-1:0]       mb_slot;
  logic [AW-1:0]       mb_addr;
  logic                fill_valid, fill_src;
  logic [SW-1:0]       fill_slot;
  logic [1:0]          cpl_valid, cpl_ready;
  logic [1:0][SW-1:0]  cpl_slot;
  logic [1:0][15:0]    acc_cnt, hit_cnt;

  l2_miss_arbiter #(.SRC_DEPTH(4), .MB_DEPTH(2), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_addr(alloc_addr), .alloc_store(alloc_store),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr), .lkp_store(lkp_store),
    .lkp_hit(lkp_hit),
    .mb_valid(mb_valid), .mb_ready(mb_ready), .mb_src(mb_src),
    .mb_slot(mb_slot), .mb_addr(mb_addr), .mb_store(mb_store),
    .fill_valid(fill_valid), .fill_src(fill_src), .fill_slot(fill_slot),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_slot(cpl_slot),
    .acc_cnt(acc_cnt), .hit_cnt(hit_cnt)
  );

  int errors = 0;
  int checks = 0;
  int bcyc   = 0;

  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  typedef struct packed {
    logic        side;
    logic [31:0] addr;
    logic        st;
    logic        hit;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 32'h0000_1040, 1'b1, 1'b1},
    '{1'b1, 32'h0000_2080, 1'b1, 1'b1},
    '{1'b0, 32'h0000_30c0, 1'b0, 1'b0},
    '{1'b1, 32'h0000_4100, 1'b0, 1'b0},
    '{1'b1, 32'h0000_5140, 1'b1, 1'b0},
    '{1'b0, 32'h0000_6180, 1'b0, 1'b1}
  };

  task automatic pop_head(input logic exp_src, input logic [AW-1:0] exp_addr, input string req);
    int guard = 0;
    while (!mb_valid && guard < 60) begin
      tick();
      guard++;
    end
    chk({req, " head side"}, 64'(mb_src), 64'(exp_src));
    chk({req, " head addr"}, 64'(mb_addr), 64'(exp_addr));
    mb_ready = 1'b1;
    tick();
    mb_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    alloc_valid = '0; alloc_store = '0; alloc_addr = '0;
    lkp_hit = '0; mb_ready = 1'b0; fill_valid = 1'b0; fill_src = 1'b0;
    fill_slot = '0; cpl_ready = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 alloc_ready", 64'(alloc_ready), 64'(2'b11));
    chk("R1 lkp_valid", 64'(lkp_valid), 64'(0));
    chk("R1 mb_valid", 64'(mb_valid), 64'(0));
    chk("R1 cpl_valid", 64'(cpl_valid), 64'(0));
    chk("R1 counters", 64'({acc_cnt, hit_cnt}), 64'(0));

    // Vector table: single entries, one side at a time
    for (int v = 0; v < 6; v++) begin
      vec_t e;
      logic s;
      e = VEC[v];
      s = e.side;
      tick();
      alloc_valid[s] = 1'b1; alloc_addr[s] = e.addr; alloc_store[s] = e.st;
      tick();
      alloc_valid[s] = 1'b0;
      settle();
      chk("R2 not early", 64'(lkp_valid[s]), 64'(0));
      tick();
      lkp_hit[s] = e.hit;
      settle();
      chk("R2 probe due", 64'(lkp_valid[s]), 64'(1));
      chk("R3 probe addr", 64'(lkp_addr[s]), 64'(e.addr));
      chk("R8 store flag", 64'(lkp_store[s]), 64'(s & e.st));
      tick();
      lkp_hit[s] = 1'b0;
      settle();
      chk("R3 sent once", 64'(lkp_valid[s]), 64'(0));
      repeat (16) tick();
      if (e.hit) begin
        chk("R5 not early", 64'(cpl_valid[s]), 64'(0));
        tick();
        chk("R5 completion", 64'(cpl_valid[s]), 64'(1));
        chk("R10 slot", 64'(cpl_slot[s]), 64'(0));
        cpl_ready[s] = 1'b1;
        tick();
        cpl_ready[s] = 1'b0;
        settle();
        chk("R10 freed", 64'(cpl_valid[s]), 64'(0));
      end else begin
        chk("R6 not early", 64'(mb_valid), 64'(0));
        tick();
        chk("R6 head due", 64'(mb_valid), 64'(1));
        chk("R6 side", 64'(mb_src), 64'(s));
        chk("R6 addr", 64'(mb_addr), 64'(e.addr));
        chk("R6 store", 64'(mb_store), 64'(s & e.st));
        chk("R6 slot", 64'(mb_slot), 64'(0));
        mb_ready = 1'b1;
        tick();
        mb_ready = 1'b0;
        fill_valid = 1'b1; fill_src = s; fill_slot = '0;
        settle();
        chk("R9 not yet", 64'(cpl_valid[s]), 64'(0));
        tick();
        fill_valid = 1'b0;
        settle();
        chk("R9 filled", 64'(cpl_valid[s]), 64'(1));
        cpl_ready[s] = 1'b1;
        tick();
        cpl_ready[s] = 1'b0;
      end
    end
    chk("R11 instr acc", 64'(acc_cnt[0]), 64'(3));
    chk("R11 instr hit", 64'(hit_cnt[0]), 64'(2));
    chk("R11 data acc", 64'(acc_cnt[1]), 64'(3));
    chk("R11 data hit", 64'(hit_cnt[1]), 64'(1));

    // R4 / R7: queue with one free place, both sides miss together
    begin
      logic fs;
      tick();
      alloc_valid[0] = 1'b1; alloc_addr[0] = 32'h100;
      tick();
      alloc_valid[0] = 1'b0;
      tick();
      tick();
      alloc_valid = 2'b11; alloc_addr[0] = 32'h200; alloc_addr[1] = 32'h300;
      alloc_store = 2'b00;
      tick();
      alloc_valid = 2'b00;
      tick();
      fs = bcyc[0];
      settle();
      chk("R4 both probe", 64'(lkp_valid), 64'(2'b11));
      tick();
      settle();
      chk("R4 first taken", 64'(lkp_valid[fs]), 64'(0));
      chk("R7 second retries", 64'(lkp_valid[!fs]), 64'(1));
      chk("R7 addr kept", 64'(lkp_addr[!fs]), 64'(fs ? 32'h200 : 32'h300));
      pop_head(1'b0, 32'h100, "R6 order old");
      pop_head(fs, fs ? 32'h300 : 32'h200, "R4 winner");
      pop_head(!fs, fs ? 32'h200 : 32'h300, "R7 loser");
    end

    // R9: fill on a free slot is ignored
    fill_valid = 1'b1; fill_src = 1'b0; fill_slot = 2'd2;
    tick();
    fill_valid = 1'b0;
    settle();
    chk("R9 ignored", 64'(cpl_valid[0]), 64'(0));

    // clean up the three waiting entries
    fill_valid = 1'b1; fill_src = 1'b0; fill_slot = 2'd0;
    tick();
    fill_slot = 2'd1;
    tick();
    fill_src = 1'b1; fill_slot = 2'd0;
    tick();
    fill_valid = 1'b0;
    cpl_ready = 2'b11;
    repeat (4) tick();
    cpl_ready = 2'b00;
    settle();
    chk("R10 drained", 64'(cpl_valid), 64'(0));

    // R12 / R10: fill the data table, all hits
    lkp_hit[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      alloc_valid[1] = 1'b1; alloc_addr[1] = 32'h800 + 32'(k * 64); alloc_store[1] = 1'b1;
      tick();
    end
    alloc_valid[1] = 1'b0;
    settle();
    chk("R12 table full", 64'(alloc_ready[1]), 64'(0));
    repeat (25) tick();
    chk("R10 lowest first", 64'(cpl_slot[1]), 64'(0));
    chk("R10 offered", 64'(cpl_valid[1]), 64'(1));
    tick();
    chk("R10 held", 64'(cpl_valid[1]), 64'(1));
    chk("R10 held slot", 64'(cpl_slot[1]), 64'(0));
    cpl_ready[1] = 1'b1;
    tick();
    chk("R10 next slot", 64'(cpl_slot[1]), 64'(1));
    repeat (3) tick();
    cpl_ready[1] = 1'b0;
    lkp_hit[1] = 1'b0;
    settle();
    chk("R12 space again", 64'(alloc_ready[1]), 64'(1));
    chk("R11 data hits", 64'(hit_cnt[1]), 64'(5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule